// File: doc/BRIEF.md
# Priority Throttle Request Arbiter

The block gathers a small set of hardware throttle requests (for example a mild thermal event, a severe thermal event and an overcurrent alarm) and settles them into one clock-throttling setting for the CPU and the GPU. Each request source owns a stored configuration: a priority from 1 to 100, a CPU depth expressed as the percentage of clock pulses to skip, and a two-bit GPU level code. Every source is an on/off request: it is either fully engaged or not engaged at all.

Software loads a source's configuration through one write port that carries all three fields at once. On every clock the arbiter looks at the trigger inputs, picks the engaged source with the largest priority, and registers that source's CPU depth, GPU code and index together with a valid flag. Ties go to the lower index, and a priority of zero takes a source out of the contest. Downstream pulse skippers consume the registered outputs directly.

Top module: `thr_arbiter`

## Requirements
- R1: After reset every source holds priority 0, CPU depth 0 and GPU code 0, so triggers have no effect until a source is configured, and the outputs read valid 0, source 0, depth 0, GPU code 0.
- R2: A write with `wr_en_i` high stores priority, CPU depth and GPU code into source `wr_idx_i` at the clock edge; a write to an index at or above the source count changes nothing.
- R3: A written priority above 100 is stored as 100.
- R4: A written CPU depth above 100 is stored as 100; the CPU depth output never exceeds 100.
- R5: With one or more engaged sources of nonzero priority, the output carries valid 1, the index of the engaged source with the largest priority, and that source's CPU depth and GPU code.
- R6: A source with priority 0 never wins, even when triggered.
- R7: When engaged sources share the largest priority, the lowest index among them wins.
- R8: When no source qualifies, the output reads valid 0, source 0, CPU depth 0 and GPU code 0 (NONE).
- R9: Outputs are registered: they reflect the triggers and configuration sampled at the previous rising clock edge, and do not change between edges.
- R10: The GPU code is forwarded unchanged with encoding 0 = NONE (0 %), 1 = LOW (50 %), 2 = MED (75 %), 3 = HIGH (85 %).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_idx_i | input | IDX_W | Source index addressed by the write |
| wr_prio_i | input | 7 | Priority to store (0 disables, saturates at 100) |
| wr_cpu_i | input | 7 | CPU depth in percent (saturates at 100) |
| wr_gpu_i | input | 2 | GPU level code |
| trig_i | input | N_SRC | One trigger bit per source |
| thr_valid_o | output | 1 | A source is selected |
| thr_src_o | output | IDX_W | Index of the selected source |
| thr_cpu_o | output | 7 | CPU depth of the selected source |
| thr_gpu_o | output | 2 | GPU code of the selected source |

## Verification
On every cycle the assertions check that stored priorities stay within range, that the CPU depth output never passes 100, that an idle output carries all-zero fields, that no trigger in the previous cycle means no valid output, and that any reported winner had its trigger set one cycle earlier. Which source should win under a given mix of priorities, the tie rule, saturation of oversized writes, ignored out-of-range writes and the one-cycle latency can only be shown by the bench's scenarios, which compare against values worked out from the programmed configuration.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam int PRIO_W   = 7;
    localparam int PCT_W    = 7;
    localparam int GPU_W    = 2;
    localparam int PRIO_MAX = 100;
    localparam int PCT_MAX  = 100;

    // GPU level codes
    localparam logic [GPU_W-1:0] GPU_NONE = 2'd0;
    localparam logic [GPU_W-1:0] GPU_LOW  = 2'd1;
    localparam logic [GPU_W-1:0] GPU_MED  = 2'd2;
    localparam logic [GPU_W-1:0] GPU_HIGH = 2'd3;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [PCT_W-1:0]  cpu;
        logic [GPU_W-1:0]  gpu;
    } src_cfg_t;

endpackage

// File: rtl/thr_cfg_bank.sv
module thr_cfg_bank
    import thr_pkg::*;
#(
    parameter int N_SRC = 3,
    parameter int IDX_W = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [PRIO_W-1:0]    wr_prio_i,
    input  logic [PCT_W-1:0]     wr_cpu_i,
    input  logic [GPU_W-1:0]     wr_gpu_i,
    output src_cfg_t             cfg_o [N_SRC]
);

    localparam logic [IDX_W:0]    NSRC_L   = (IDX_W+1)'(N_SRC);
    localparam logic [PRIO_W-1:0] PRIO_TOP = PRIO_W'(PRIO_MAX);
    localparam logic [PCT_W-1:0]  PCT_TOP  = PCT_W'(PCT_MAX);

    src_cfg_t cfg_d [N_SRC];
    src_cfg_t cfg_q [N_SRC];
    src_cfg_t wr_ent;

    always_comb begin
        wr_ent.prio = (wr_prio_i > PRIO_TOP) ? PRIO_TOP : wr_prio_i;
        wr_ent.cpu  = (wr_cpu_i  > PCT_TOP)  ? PCT_TOP  : wr_cpu_i;
        wr_ent.gpu  = wr_gpu_i;
        for (int i = 0; i < N_SRC; i++) begin
            cfg_d[i] = cfg_q[i];
            if (wr_en_i && ({1'b0, wr_idx_i} < NSRC_L) && (wr_idx_i == IDX_W'(i)))
                cfg_d[i] = wr_ent;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < N_SRC; i++) cfg_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_SRC; i++) cfg_q[i] <= cfg_d[i];
        end
    end

    assign cfg_o = cfg_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        assert_prio_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfg_q[g].prio <= PRIO_TOP);
        assert_depth_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfg_q[g].cpu <= PCT_TOP);
    end

endmodule

// File: rtl/thr_pick.sv
module thr_pick
    import thr_pkg::*;
#(
    parameter int N_SRC = 3,
    parameter int IDX_W = 2
) (
    input  src_cfg_t             cfg_i [N_SRC],
    input  logic [N_SRC-1:0]     trig_i,
    output logic                 win_valid_o,
    output logic [IDX_W-1:0]     win_idx_o,
    output logic [PCT_W-1:0]     win_cpu_o,
    output logic [GPU_W-1:0]     win_gpu_o
);

    logic [PRIO_W-1:0] eff_prio [N_SRC];

    // an idle source bids priority 0, which never beats anything
    for (genvar g = 0; g < N_SRC; g++) begin : g_bid
        assign eff_prio[g] = trig_i[g] ? cfg_i[g].prio : '0;
    end

    logic [PRIO_W-1:0] best_prio;
    logic [IDX_W-1:0]  best_idx;

    always_comb begin
        best_prio = '0;
        best_idx  = '0;
        // strict compare keeps the lower index on equal priority
        for (int i = 0; i < N_SRC; i++) begin
            if (eff_prio[i] > best_prio) begin
                best_prio = eff_prio[i];
                best_idx  = IDX_W'(i);
            end
        end
        win_valid_o = (best_prio != '0);
        win_idx_o   = win_valid_o ? best_idx : '0;
        win_cpu_o   = win_valid_o ? cfg_i[best_idx].cpu : '0;
        win_gpu_o   = win_valid_o ? cfg_i[best_idx].gpu : GPU_NONE;
    end

endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter
    import thr_pkg::*;
#(
    parameter int N_SRC = 3,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [PRIO_W-1:0]    wr_prio_i,
    input  logic [PCT_W-1:0]     wr_cpu_i,
    input  logic [GPU_W-1:0]     wr_gpu_i,
    input  logic [N_SRC-1:0]     trig_i,
    output logic                 thr_valid_o,
    output logic [IDX_W-1:0]     thr_src_o,
    output logic [PCT_W-1:0]     thr_cpu_o,
    output logic [GPU_W-1:0]     thr_gpu_o
);

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  src;
        logic [PCT_W-1:0]  cpu;
        logic [GPU_W-1:0]  gpu;
    } out_t;

    src_cfg_t cfg [N_SRC];
    out_t     out_d;
    out_t     out_q;
    logic                win_valid;
    logic [IDX_W-1:0]    win_idx;
    logic [PCT_W-1:0]    win_cpu;
    logic [GPU_W-1:0]    win_gpu;

    thr_cfg_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_prio_i (wr_prio_i),
        .wr_cpu_i  (wr_cpu_i),
        .wr_gpu_i  (wr_gpu_i),
        .cfg_o     (cfg)
    );

    thr_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .cfg_i       (cfg),
        .trig_i      (trig_i),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_cpu_o   (win_cpu),
        .win_gpu_o   (win_gpu)
    );

    always_comb begin
        out_d.valid = win_valid;
        out_d.src   = win_idx;
        out_d.cpu   = win_cpu;
        out_d.gpu   = win_gpu;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign thr_valid_o = out_q.valid;
    assign thr_src_o   = out_q.src;
    assign thr_cpu_o   = out_q.cpu;
    assign thr_gpu_o   = out_q.gpu;

    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !thr_valid_o |-> (thr_cpu_o == '0 && thr_gpu_o == GPU_NONE && thr_src_o == '0));

    assert_no_trig_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(trig_i) == '0) |-> !thr_valid_o);

    assert_winner_engaged_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_valid_o |-> ((($past(trig_i)) >> thr_src_o) & N_SRC'(1)) != '0);

    assert_cpu_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thr_cpu_o <= PCT_W'(PCT_MAX));

endmodule

// File: tb/thr_arbiter_tb.sv
`timescale 1ns/1ps
module thr_arbiter_tb;

    localparam int N = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [6:0]    wr_prio = '0;
    logic [6:0]    wr_cpu = '0;
    logic [1:0]    wr_gpu = '0;
    logic [N-1:0]  trig = '0;
    logic          v_o;
    logic [IW-1:0] s_o;
    logic [6:0]    c_o;
    logic [1:0]    g_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    thr_arbiter #(.N_SRC(N)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_prio_i(wr_prio), .wr_cpu_i(wr_cpu), .wr_gpu_i(wr_gpu), .trig_i(trig),
        .thr_valid_o(v_o), .thr_src_o(s_o), .thr_cpu_o(c_o), .thr_gpu_o(g_o)
    );

    // {trig[2:0], valid, src[1:0], cpu[6:0], gpu[1:0]}
    // src0: prio 80 cpu 50 LOW; src1: prio 100 cpu 85 HIGH; src2: prio 50 cpu 75 MED
    localparam logic [14:0] VEC [8] = '{
        {3'b000, 1'b0, 2'd0, 7'd0,  2'd0},
        {3'b001, 1'b1, 2'd0, 7'd50, 2'd1},
        {3'b010, 1'b1, 2'd1, 7'd85, 2'd3},
        {3'b100, 1'b1, 2'd2, 7'd75, 2'd2},
        {3'b011, 1'b1, 2'd1, 7'd85, 2'd3},
        {3'b101, 1'b1, 2'd0, 7'd50, 2'd1},
        {3'b110, 1'b1, 2'd1, 7'd85, 2'd3},
        {3'b111, 1'b1, 2'd1, 7'd85, 2'd3}
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input int v, input int s, input int c, input int g);
        chk({req, " valid"}, int'(v_o), v);
        chk({req, " src"},   int'(s_o), s);
        chk({req, " cpu"},   int'(c_o), c);
        chk({req, " gpu"},   int'(g_o), g);
    endtask

    task automatic write_cfg(input int idx, input int p, input int c, input int g);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_prio = 7'(p); wr_cpu = 7'(c); wr_gpu = 2'(g);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply(input logic [N-1:0] t);
        trig = t;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        trig = 3'b111;
        repeat (3) @(negedge clk);
        chk_all("R1 in reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1 / R6: unconfigured sources have priority 0
        chk_all("R1 R6 unconfigured", 0, 0, 0, 0);

        apply('0);
        write_cfg(0, 80, 50, 1);
        write_cfg(1, 100, 85, 3);
        write_cfg(2, 50, 75, 2);

        // R2 R5 R8 R10: table walk
        for (int k = 0; k < 8; k++) begin
            apply(VEC[k][14:12]);
            chk_all($sformatf("R5 R8 R10 vec%0d", k), int'(VEC[k][11]),
                    int'(VEC[k][10:9]), int'(VEC[k][8:2]), int'(VEC[k][1:0]));
        end

        // R9: no change before the edge, new value after it
        trig = 3'b001;
        #1;
        chk("R9 before edge src", int'(s_o), 1);
        @(posedge clk); @(negedge clk);
        chk_all("R9 after edge", 1, 0, 50, 1);

        // R2: out-of-range index ignored
        write_cfg(3, 100, 100, 0);
        apply(3'b001);
        chk_all("R2 idx3 ignored", 1, 0, 50, 1);
        apply(3'b011);
        chk_all("R2 idx3 ignored both", 1, 1, 85, 3);

        // R6: disabling a source
        write_cfg(1, 0, 85, 3);
        apply(3'b011);
        chk_all("R6 prio0 loses", 1, 0, 50, 1);
        apply(3'b010);
        chk_all("R6 prio0 alone", 0, 0, 0, 0);

        // R7: tie goes to lower index
        write_cfg(2, 80, 40, 0);
        apply(3'b101);
        chk_all("R7 tie", 1, 0, 50, 1);
        apply(3'b100);
        chk_all("R10 NONE code", 1, 2, 40, 0);

        // R3: priority 120 saturates to 100, ties with src0 at 100
        write_cfg(0, 100, 50, 1);
        write_cfg(2, 120, 40, 0);
        apply(3'b101);
        chk_all("R3 clamp tie", 1, 0, 50, 1);

        // R4: depth saturates
        write_cfg(2, 60, 127, 2);
        apply(3'b100);
        chk_all("R4 depth clamp", 1, 2, 100, 2);

        // R1: reset mid-run clears configuration
        rst_n = 1'b0;
        #1;
        chk_all("R1 async reset", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(3'b111);
        apply(3'b111);
        chk_all("R1 config cleared", 0, 0, 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule